// File: doc/BRIEF.md
# Tick-Aligned Power Integrator with Gain Hand-Off

This block measures the total power of a sample stream for a gain-levelling servo. Signed samples come in on a valid/ready stream. The block keeps one sample in every DECIM accepted samples, squares it, and sums the squares over a measurement period. Each period is bounded by a pulse on an external periodic tick. At every tick the sum for the period just ended is latched, together with the number of samples that went into it. Software then reads both values, and a valid flag and an overrun flag tell it whether it has seen them.

Software also writes a gain code into a shadow register. The code reaches the DAC output only on a tick, so a period never contains a gain step partway through. When a tick changes the applied code, accumulation is suppressed for a programmable number of clock cycles while the analog gain settles. The latched sample count lets software correct the total for the suppressed part of the period.

The stream side never applies back-pressure. `s_ready_o` is held high, and a sample is accepted in every cycle in which `s_valid_i` is high. A sample the block does not keep is discarded, not stalled.

Top module: `pwr_level_meter`

## Requirements
- R1: `s_ready_o` is always 1, and a sample is accepted in every cycle with `s_valid_i` high. A sample accepted in the same cycle as `tick_i` is discarded and never counted.
- R2: The decimation phase restarts on every tick. The first accepted sample after a tick is kept, and every DECIM-th accepted sample after it is kept (DECIM = 64 by default). With consecutive samples, N accepted samples keep ceil(N/64).
- R3: Each kept sample that is not blanked adds its square to the period total. The sample is taken as two's-complement 8 bits, so full-scale -128 adds 16384. Each such sample also adds 1 to the period sample count.
- R4: On a tick, `res_power_o` and `res_count_o` take the period's total and count in the cycle after the tick. Both then hold their values until the next tick. The next period starts from zero.
- R5: `gain_dac_o` changes only in the cycle after a tick, and it then takes the shadow value. A `gain_wr_i` write updates only the shadow. A write in the same cycle as a tick is applied at the following tick.
- R6: On a tick where the shadow code differs from the applied code, `blank_o` is high for exactly L cycles, starting the cycle after the tick, where L is the settle length. Kept samples during those cycles are not summed or counted. No blanking starts if L is 0 or the codes are equal.
- R7: `res_valid_o` is set by each latch and cleared by a `res_rd_i` pulse. When the two happen in the same cycle, the latch wins.
- R8: `res_overrun_o` is set when a latch occurs while `res_valid_o` is 1 and `res_rd_i` is 0. A `res_rd_i` pulse clears it.
- R9: After reset, `gain_dac_o` is 0, `blank_o` is 0, both flags are 0, and both result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle period boundary pulse |
| s_valid_i | input | 1 | Sample stream valid |
| s_ready_o | output | 1 | Sample stream ready, always 1 |
| s_data_i | input | SAMPLE_W | Signed sample |
| gain_wr_i | input | 1 | Shadow gain write strobe |
| gain_data_i | input | GAIN_W | Gain code to write |
| settle_wr_i | input | 1 | Settle length write strobe |
| settle_data_i | input | SETTLE_W | Settle length in clock cycles |
| gain_dac_o | output | GAIN_W | Gain code applied to the DAC |
| blank_o | output | 1 | Accumulation suppressed for settling |
| res_rd_i | input | 1 | Result read strobe |
| res_valid_o | output | 1 | A latched result has not been read |
| res_overrun_o | output | 1 | A result was overwritten before it was read |
| res_power_o | output | ACC_W | Latched sum of squares |
| res_count_o | output | CNT_W | Latched count of summed samples |

## Verification
A wrong decimation phase shows up at the next latch as a sample count off by one. This is most visible when a period starts partway through a decimation cycle, and with 65 samples the count is 2 when correct and 1 when wrong. A wrong blanking length shows up directly on `blank_o`, which is checked in the exact cycle where it must fall. It also shows up one period later as a count that includes or drops a sample at the start of the period. Errors in the shadow register or the flags are visible in the cycle right after the tick or the read strobe that should have moved them.

// File: rtl/plm_pkg.sv
package plm_pkg;
  localparam int unsigned DEF_SAMPLE_W   = 8;
  localparam int unsigned DEF_DECIM      = 64;
  localparam int unsigned DEF_GAIN_W     = 10;
  localparam int unsigned DEF_ACC_W      = 40;
  localparam int unsigned DEF_CNT_W      = 24;
  localparam int unsigned DEF_SETTLE_W   = 20;
  localparam int unsigned DEF_SETTLE_RST = 150000;

  typedef enum logic {
    GC_RUN    = 1'b0,
    GC_SETTLE = 1'b1
  } gain_state_e;
endpackage

// File: rtl/plm_decim.sv
module plm_decim #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned DECIM    = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                in_valid_i,
  input  logic [SAMPLE_W-1:0] in_data_i,
  output logic                keep_o,
  output logic [SAMPLE_W-1:0] keep_data_o
);
  assign keep_data_o = in_data_i;

  generate
    if (DECIM <= 1) begin : g_pass
      assign keep_o = in_valid_i && !tick_i;
    end else begin : g_count
      localparam int unsigned PH_W = $clog2(DECIM);
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(DECIM - 1);
      logic [PH_W-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phase_q <= '0;
        end else if (tick_i) begin
          phase_q <= '0;
        end else if (in_valid_i) begin
          phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
        end
      end

      assign keep_o = in_valid_i && !tick_i && (phase_q == '0);
    end
  endgenerate
endmodule

// File: rtl/plm_power_acc.sv
module plm_power_acc #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned ACC_W    = 40,
  parameter int unsigned CNT_W    = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                keep_i,
  input  logic                blank_i,
  input  logic [SAMPLE_W-1:0] data_i,
  output logic [ACC_W-1:0]    sum_o,
  output logic [CNT_W-1:0]    cnt_o
);
  localparam int unsigned SQ_W = 2 * SAMPLE_W;

  logic signed [SAMPLE_W-1:0] samp;
  logic signed [SQ_W-1:0]     samp_x;
  logic signed [SQ_W-1:0]     prod;
  logic        [SQ_W-1:0]     square;
  logic                       add_en;
  logic [ACC_W-1:0]           sum_q;
  logic [CNT_W-1:0]           cnt_q;

  assign samp   = $signed(data_i);
  assign samp_x = SQ_W'(samp);
  assign prod   = samp_x * samp_x;
  assign square = $unsigned(prod);
  assign add_en = keep_i && !blank_i && !tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (tick_i) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (add_en) begin
      sum_q <= sum_q + ACC_W'(square);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sum_o = sum_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/plm_gain_ctrl.sv
module plm_gain_ctrl
  import plm_pkg::*;
#(
  parameter int unsigned GAIN_W     = 10,
  parameter int unsigned SETTLE_W   = 20,
  parameter int unsigned SETTLE_RST = 150000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                gain_wr_i,
  input  logic [GAIN_W-1:0]   gain_data_i,
  input  logic                settle_wr_i,
  input  logic [SETTLE_W-1:0] settle_data_i,
  output logic [GAIN_W-1:0]   gain_dac_o,
  output logic [GAIN_W-1:0]   shadow_o,
  output logic [SETTLE_W-1:0] settle_len_o,
  output logic                blank_o
);
  logic [GAIN_W-1:0]   shadow_q;
  logic [GAIN_W-1:0]   dac_q;
  logic [SETTLE_W-1:0] settle_len_q;
  logic [SETTLE_W-1:0] remain_q;
  gain_state_e         state_q;
  logic                start_blank;

  assign start_blank = tick_i && (shadow_q != dac_q) && (settle_len_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q     <= '0;
      settle_len_q <= SETTLE_W'(SETTLE_RST);
    end else begin
      if (gain_wr_i)   shadow_q     <= gain_data_i;
      if (settle_wr_i) settle_len_q <= settle_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q <= '0;
    end else if (tick_i) begin
      dac_q <= shadow_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= GC_RUN;
      remain_q <= '0;
    end else if (start_blank) begin
      state_q  <= GC_SETTLE;
      remain_q <= settle_len_q;
    end else if (state_q == GC_SETTLE) begin
      if (remain_q <= SETTLE_W'(1)) begin
        state_q  <= GC_RUN;
        remain_q <= '0;
      end else begin
        remain_q <= remain_q - 1'b1;
      end
    end
  end

  assign gain_dac_o   = dac_q;
  assign shadow_o     = shadow_q;
  assign settle_len_o = settle_len_q;
  assign blank_o      = (state_q == GC_SETTLE);
endmodule

// File: rtl/plm_result_reg.sv
module plm_result_reg #(
  parameter int unsigned ACC_W = 40,
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             rd_i,
  input  logic [ACC_W-1:0] sum_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [ACC_W-1:0] power_o,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o,
  output logic             overrun_o
);
  logic [ACC_W-1:0] power_q;
  logic [CNT_W-1:0] count_q;
  logic             valid_q;
  logic             overrun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      power_q <= '0;
      count_q <= '0;
    end else if (tick_i) begin
      power_q <= sum_i;
      count_q <= cnt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      if (tick_i)    valid_q <= 1'b1;
      else if (rd_i) valid_q <= 1'b0;

      if (rd_i)                    overrun_q <= 1'b0;
      else if (tick_i && valid_q)  overrun_q <= 1'b1;
    end
  end

  assign power_o   = power_q;
  assign count_o   = count_q;
  assign valid_o   = valid_q;
  assign overrun_o = overrun_q;
endmodule

// File: rtl/pwr_level_meter.sv
module pwr_level_meter
  import plm_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = DEF_SAMPLE_W,
  parameter int unsigned DECIM      = DEF_DECIM,
  parameter int unsigned GAIN_W     = DEF_GAIN_W,
  parameter int unsigned ACC_W      = DEF_ACC_W,
  parameter int unsigned CNT_W      = DEF_CNT_W,
  parameter int unsigned SETTLE_W   = DEF_SETTLE_W,
  parameter int unsigned SETTLE_RST = DEF_SETTLE_RST
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                s_valid_i,
  output logic                s_ready_o,
  input  logic [SAMPLE_W-1:0] s_data_i,
  input  logic                gain_wr_i,
  input  logic [GAIN_W-1:0]   gain_data_i,
  input  logic                settle_wr_i,
  input  logic [SETTLE_W-1:0] settle_data_i,
  output logic [GAIN_W-1:0]   gain_dac_o,
  output logic                blank_o,
  input  logic                res_rd_i,
  output logic                res_valid_o,
  output logic                res_overrun_o,
  output logic [ACC_W-1:0]    res_power_o,
  output logic [CNT_W-1:0]    res_count_o
);
  logic                keep;
  logic [SAMPLE_W-1:0] keep_data;
  logic                blank;
  logic [ACC_W-1:0]    run_sum;
  logic [CNT_W-1:0]    run_cnt;
  logic [GAIN_W-1:0]   gain_shadow;
  logic [SETTLE_W-1:0] settle_len;
  logic                accept;

  assign s_ready_o = 1'b1;
  assign accept    = s_valid_i && s_ready_o;

  plm_decim #(.SAMPLE_W(SAMPLE_W), .DECIM(DECIM)) u_decim (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .in_valid_i  (accept),
    .in_data_i   (s_data_i),
    .keep_o      (keep),
    .keep_data_o (keep_data)
  );

  plm_gain_ctrl #(.GAIN_W(GAIN_W), .SETTLE_W(SETTLE_W), .SETTLE_RST(SETTLE_RST)) u_gain (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .gain_wr_i     (gain_wr_i),
    .gain_data_i   (gain_data_i),
    .settle_wr_i   (settle_wr_i),
    .settle_data_i (settle_data_i),
    .gain_dac_o    (gain_dac_o),
    .shadow_o      (gain_shadow),
    .settle_len_o  (settle_len),
    .blank_o       (blank)
  );

  plm_power_acc #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .keep_i  (keep),
    .blank_i (blank),
    .data_i  (keep_data),
    .sum_o   (run_sum),
    .cnt_o   (run_cnt)
  );

  plm_result_reg #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .rd_i      (res_rd_i),
    .sum_i     (run_sum),
    .cnt_i     (run_cnt),
    .power_o   (res_power_o),
    .count_o   (res_count_o),
    .valid_o   (res_valid_o),
    .overrun_o (res_overrun_o)
  );

  assign blank_o = blank;
endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
  parameter int unsigned GAIN_W   = 10,
  parameter int unsigned SETTLE_W = 20,
  parameter int unsigned ACC_W    = 40,
  parameter int unsigned CNT_W    = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_i,
  input logic                res_rd_i,
  input logic [GAIN_W-1:0]   gain_dac_o,
  input logic [GAIN_W-1:0]   gain_shadow,
  input logic [SETTLE_W-1:0] settle_len,
  input logic                blank_o,
  input logic                res_valid_o,
  input logic                res_overrun_o,
  input logic [ACC_W-1:0]    res_power_o,
  input logic [CNT_W-1:0]    res_count_o
);
  a_r5_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(gain_dac_o));

  a_r5_dac_load: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> gain_dac_o == $past(gain_shadow));

  a_r6_blank_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && gain_shadow != gain_dac_o && settle_len != '0) |=> blank_o);

  a_r6_no_spurious_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && gain_shadow == gain_dac_o && !blank_o) |=> !blank_o);

  a_r4_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(res_power_o) && $stable(res_count_o)));

  a_r7_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> res_valid_o);

  a_r7_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rd_i && !tick_i) |=> (!res_valid_o && !res_overrun_o));

  a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && res_valid_o && !res_rd_i) |=> res_overrun_o);
endmodule

bind pwr_level_meter plm_checker #(
  .GAIN_W(GAIN_W), .SETTLE_W(SETTLE_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_i        (tick_i),
  .res_rd_i      (res_rd_i),
  .gain_dac_o    (gain_dac_o),
  .gain_shadow   (gain_shadow),
  .settle_len    (settle_len),
  .blank_o       (blank_o),
  .res_valid_o   (res_valid_o),
  .res_overrun_o (res_overrun_o),
  .res_power_o   (res_power_o),
  .res_count_o   (res_count_o)
);

// File: tb/pwr_level_meter_tb.sv
module pwr_level_meter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        gain_wr = 1'b0;
  logic [9:0]  gain_data = '0;
  logic        settle_wr = 1'b0;
  logic [19:0] settle_data = '0;
  logic [9:0]  gain_dac;
  logic        blank;
  logic        rd = 1'b0;
  logic        valid;
  logic        overrun;
  logic [39:0] power;
  logic [23:0] count;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  pwr_level_meter u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
    .gain_wr_i(gain_wr), .gain_data_i(gain_data),
    .settle_wr_i(settle_wr), .settle_data_i(settle_data),
    .gain_dac_o(gain_dac), .blank_o(blank),
    .res_rd_i(rd), .res_valid_o(valid), .res_overrun_o(overrun),
    .res_power_o(power), .res_count_o(count)
  );

  localparam int NVEC = 6;
  localparam int          VEC_N   [NVEC] = '{1, 64, 65, 130, 200, 640};
  localparam logic [7:0]  VEC_VAL [NVEC] = '{8'h05, 8'hFD, 8'h7F, 8'h80, 8'h01, 8'h0A};
  localparam bit          VEC_GAP [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse_rd();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic write_gain(input logic [9:0] g);
    gain_wr = 1'b1; gain_data = g;
    @(negedge clk);
    gain_wr = 1'b0;
  endtask

  task automatic write_settle(input logic [19:0] l);
    settle_wr = 1'b1; settle_data = l;
    @(negedge clk);
    settle_wr = 1'b0;
  endtask

  task automatic send(input int n, input logic [7:0] v, input bit gap);
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1; s_data = v;
      @(negedge clk);
      if (gap) begin
        s_valid = 1'b0;
        @(negedge clk);
      end
    end
    s_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 dac", gain_dac, 0);
    chk("R9 valid", valid, 0);
    chk("R9 overrun", overrun, 0);
    chk("R9 blank", blank, 0);
    chk("R9 power", power, 0);
    chk("R9 count", count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", s_ready, 1);

    pulse_tick();
    pulse_rd();

    // R2 R3 R4: table of periods
    for (int k = 0; k < NVEC; k++) begin
      automatic int kept = (VEC_N[k] + 63) / 64;
      automatic int sv = int'($signed(VEC_VAL[k]));
      send(VEC_N[k], VEC_VAL[k], VEC_GAP[k]);
      pulse_tick();
      chk($sformatf("R3 power vec%0d", k), power, longint'(kept) * sv * sv);
      chk($sformatf("R2 count vec%0d", k), count, kept);
      pulse_rd();
    end

    // R4: result holds between ticks while new samples arrive
    send(64, 8'h02, 1'b0);
    chk("R4 hold power", power, 100 * 10);
    pulse_tick();
    pulse_rd();

    // R5 R6: shadow gain, blanking drops kept samples
    write_settle(20'd10);
    write_gain(10'h155);
    chk("R5 shadow not applied", gain_dac, 0);
    pulse_tick();
    chk("R5 applied on tick", gain_dac, 10'h155);
    chk("R6 blank after change", blank, 1);
    send(192, 8'h04, 1'b0);
    pulse_tick();
    chk("R6 no blank same gain", blank, 0);
    chk("R6 blanked count", count, 2);
    chk("R6 blanked power", power, 32);
    pulse_rd();

    // R6: exact blank length
    write_gain(10'h2AA);
    pulse_tick();
    repeat (9) @(negedge clk);
    chk("R6 blank last cycle", blank, 1);
    @(negedge clk);
    chk("R6 blank ended", blank, 0);
    pulse_rd();

    // R5: write in tick cycle applies at the following tick
    gain_wr = 1'b1; gain_data = 10'h0F0; tick = 1'b1;
    @(negedge clk);
    gain_wr = 1'b0; tick = 1'b0;
    chk("R5 tick-cycle write deferred", gain_dac, 10'h2AA);
    pulse_tick();
    chk("R5 deferred write applied", gain_dac, 10'h0F0);
    repeat (12) @(negedge clk);
    pulse_rd();

    // R6: zero settle length never blanks
    write_settle(20'd0);
    write_gain(10'h001);
    pulse_tick();
    chk("R6 zero length no blank", blank, 0);
    chk("R5 dac after zero-length", gain_dac, 1);
    pulse_rd();

    // R1: sample in tick cycle discarded
    tick = 1'b1; s_valid = 1'b1; s_data = 8'd100;
    @(negedge clk);
    tick = 1'b0; s_data = 8'd3;
    @(negedge clk);
    s_valid = 1'b0;
    pulse_tick();
    chk("R1 tick sample count", count, 1);
    chk("R1 tick sample power", power, 9);
    pulse_rd();

    // R2: phase restarts on tick mid-cycle
    send(10, 8'h01, 1'b0);
    pulse_tick();
    chk("R2 partial count", count, 1);
    pulse_rd();
    send(65, 8'h02, 1'b0);
    pulse_tick();
    chk("R2 phase reset count", count, 2);
    chk("R2 phase reset power", power, 8);
    pulse_rd();

    // R8: overrun and its clearing
    pulse_tick();
    pulse_tick();
    chk("R8 valid", valid, 1);
    chk("R8 overrun set", overrun, 1);
    pulse_rd();
    chk("R7 valid cleared", valid, 0);
    chk("R8 overrun cleared", overrun, 0);

    // R7: latch wins over read in the same cycle
    pulse_tick();
    tick = 1'b1; rd = 1'b1;
    @(negedge clk);
    tick = 1'b0; rd = 1'b0;
    chk("R7 latch wins valid", valid, 1);
    chk("R8 no overrun with read", overrun, 0);
    pulse_rd();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule